// File: doc/BRIEF.md
# Board Interrupt-Level Encoder with Registers

This block gathers thirteen level-sensitive interrupt request lines from board peripherals, folds them into a 16-bit pending word, gates that word with a software-written enable mask, and presents a single 4-bit encoded interrupt level to the processor. Each request line has a fixed priority from 0 to 12. Among the enabled, pending lines, the one with the smallest priority number wins. The level driven out is that priority XORed with 15, so the output is 0 when nothing is pending and 15 when priority 0 is pending.

A small 16-bit register window on a simple memory-mapped bus holds the enable mask and a general-purpose output port. The window also has a fixed identification register and a power-off control word, which produces a one-cycle shutdown pulse. Writes take effect on the clock edge where select and write are both high. Read data is combinational while select is high and write is low.

Top module: `board_irq_encoder`

## Requirements
- R1: After reset, `irl_out`, `gpo` and `shutdown_req` are 0, and the mask register reads 0.
- R2: Request line `irq_src[p]` (p is its priority) sets a fixed bit of the pending/mask word. The bit for each p is: p0→11, p1→9, p2→8, p3→12, p4→10, p5→6, p6→5, p7→4, p8→7, p9→14, p10→13, p11→0, p12→15.
- R3: When several lines are pending and enabled, the smallest priority number determines the level.
- R4: `irl_out` equals 15 XOR the selected priority, and is 0 when no enabled line is pending.
- R5: A pending line whose mask bit is 0 has no effect on `irl_out`.
- R6: `irl_out` is registered. It reflects an input change, or a mask write, at the first rising clock edge after that change or write.
- R7: Byte offset 0x00 is the mask register. It can be written and read back, 16 bits wide.
- R8: Byte offset 0x36 is the output port. A write drives `gpo`, and a read returns the same value.
- R9: Byte offset 0x32 always reads 0x0010. Writes to it change nothing.
- R10: Byte offset 0x30 reads 0. A write with bit 0 set makes `shutdown_req` high for exactly the one cycle after the write edge. A write with bit 0 clear produces no pulse.
- R11: Reads of any other offset in the 0x40-byte window return 0. Writes to other offsets change neither the mask nor `gpo`.
- R12: The pending state is level-sensitive. Lowering a request line removes it from the encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 13 | Request lines, index = priority |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window (bit 0 ignored) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (0 when not reading) |
| irl_out | output | 4 | Encoded interrupt level |
| gpo | output | 16 | General-purpose output port |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
The bench walks every priority alone to catch a bit-mapping mix-up, which would yield the wrong level or none at all. It pits priorities against each other to catch an encoder that picks the largest index, and it masks the top-priority line to confirm that the next enabled one shows through. It samples the level just before and just after the edge that follows an input change or a mask write, which exposes an extra pipeline stage or a level computed from the stale mask. It also writes to the identification register and to unmapped offsets, then probes the power-off word with bit 0 clear and set. A wrong decode there would corrupt the mask or port, or fire a spurious shutdown.

// File: rtl/board_irq_encoder.sv
module board_irq_encoder #(
  parameter int          NSRC   = 13,
  parameter int          DW     = 16,
  parameter int          AW     = 6,
  parameter logic [15:0] ID_VAL = 16'h0010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic [3:0]      irl_out,
  output logic [DW-1:0]   gpo,
  output logic            shutdown_req
);
  localparam logic [AW-2:0] OFS_MASK = (AW-1)'(6'h00 >> 1);
  localparam logic [AW-2:0] OFS_PWR  = (AW-1)'(6'h30 >> 1);
  localparam logic [AW-2:0] OFS_ID   = (AW-1)'(6'h32 >> 1);
  localparam logic [AW-2:0] OFS_PORT = (AW-1)'(6'h36 >> 1);

  function automatic int bit_of(input int p);
    case (p)
      0: return 11;  1: return 9;   2: return 8;   3: return 12;
      4: return 10;  5: return 6;   6: return 5;   7: return 4;
      8: return 7;   9: return 14;  10: return 13; 11: return 0;
      default: return 15;
    endcase
  endfunction

  logic [DW-1:0] mask_q, mask_nxt, pend;
  logic [3:0]    best;
  logic [AW-2:0] word;
  logic          wr_en, rd_en;

  assign word  = bus_addr[AW-1:1];
  assign wr_en = bus_sel && bus_wr;
  assign rd_en = bus_sel && !bus_wr;
  assign mask_nxt = (wr_en && word == OFS_MASK) ? bus_wdata : mask_q;

  always_comb begin
    pend = '0;
    for (int p = 0; p < NSRC; p++) pend[bit_of(p)] = irq_src[p];
  end

  always_comb begin
    best = 4'hF;
    for (int p = NSRC-1; p >= 0; p--)
      if (pend[bit_of(p)] && mask_nxt[bit_of(p)]) best = 4'(p);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q       <= '0;
      gpo          <= '0;
      irl_out      <= '0;
      shutdown_req <= 1'b0;
    end else begin
      mask_q       <= mask_nxt;
      irl_out      <= best ^ 4'hF;
      shutdown_req <= wr_en && word == OFS_PWR && bus_wdata[0];
      if (wr_en && word == OFS_PORT) gpo <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en)
      case (word)
        OFS_MASK: bus_rdata = mask_q;
        OFS_ID:   bus_rdata = ID_VAL;
        OFS_PORT: bus_rdata = gpo;
        default:  bus_rdata = '0;
      endcase
  end
endmodule

// File: rtl/board_irq_encoder_chk.sv
module board_irq_encoder_chk #(
  parameter int NSRC = 13,
  parameter int DW   = 16,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_src,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [3:0]      irl_out,
  input logic [DW-1:0]   gpo,
  input logic            shutdown_req
);
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (irl_out != 4'd0) |-> $past(|irq_src));

  a_r10_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(bus_sel && bus_wr && bus_addr[AW-1:1] == 5'h18 && bus_wdata[0]));

  a_r10_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[AW-1:1] == 5'h18) |-> bus_rdata == '0);

  a_r9_id_value: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[AW-1:1] == 5'h19) |-> bus_rdata == 16'h0010);

  a_r8_port_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[AW-1:1] == 5'h1B) |=> gpo == $past(bus_wdata));

  a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (irl_out == 4'hF) |-> $past(irq_src[0]));
endmodule

bind board_irq_encoder board_irq_encoder_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/board_irq_encoder_tb.sv
module board_irq_encoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] irq_src = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  irl_out;
  logic [15:0] gpo;
  logic        shutdown_req;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  board_irq_encoder u_dut (.*);

  function automatic int pos(input int p);
    int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    return t[p];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 irl", 16'(irl_out), 16'h0);
    check("R1 gpo", gpo, 16'h0);
    check("R1 shutdown", 16'(shutdown_req), 16'h0);
    rd(6'h00, d);
    check("R1 mask", d, 16'h0);
  endtask

  task automatic t_each_source();
    wr(6'h00, 16'hFFFF);
    for (int p = 0; p < 13; p++) begin
      irq_src = 13'(1 << p);
      settle();
      check($sformatf("R2/R4 p%0d", p), 16'(irl_out), 16'(p ^ 15));
    end
    for (int p = 0; p < 13; p++) begin
      wr(6'h00, 16'(1 << pos(p)));
      irq_src = 13'(1 << p);
      settle();
      check($sformatf("R2 bit p%0d", p), 16'(irl_out), 16'(p ^ 15));
    end
  endtask

  task automatic t_priority();
    wr(6'h00, 16'hFFFF);
    irq_src = '1; settle();
    check("R3 all", 16'(irl_out), 16'd15);
    irq_src = 13'(1 << 5) | 13'(1 << 9); settle();
    check("R3 p5 vs p9", 16'(irl_out), 16'd10);
    irq_src = 13'(1 << 12) | 13'(1 << 11); settle();
    check("R3 p11 vs p12", 16'(irl_out), 16'd4);
    irq_src = '0; settle();
    check("R4 none", 16'(irl_out), 16'd0);
  endtask

  task automatic t_mask_latency();
    irq_src = 13'd1;
    wr(6'h00, 16'hFFFF & ~(16'(1) << pos(0)));
    check("R5 p0 masked", 16'(irl_out), 16'd0);
    irq_src = '1; settle();
    wr(6'h00, 16'(1) << pos(7));
    check("R5/R6 only p7", 16'(irl_out), 16'd8);
    wr(6'h00, 16'hFFFF);
    check("R6 mask write", 16'(irl_out), 16'd15);
    irq_src = 13'(1 << 4);
    #1 check("R6 before edge", 16'(irl_out), 16'd15);
    settle();
    check("R6 after edge", 16'(irl_out), 16'd11);
  endtask

  task automatic t_level();
    irq_src = 13'(1 << 2); settle();
    check("R12 raised", 16'(irl_out), 16'd13);
    irq_src = '0; settle();
    check("R12 lowered", 16'(irl_out), 16'd0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(6'h00, 16'hA5C3); rd(6'h00, d);
    check("R7 mask rb", d, 16'hA5C3);
    wr(6'h36, 16'h1234);
    check("R8 gpo", gpo, 16'h1234);
    rd(6'h36, d);
    check("R8 port rb", d, 16'h1234);
    rd(6'h32, d);
    check("R9 id", d, 16'h0010);
    wr(6'h32, 16'hFFFF); rd(6'h32, d);
    check("R9 id after write", d, 16'h0010);
    rd(6'h00, d);
    check("R9 mask intact", d, 16'hA5C3);
    check("R9 gpo intact", gpo, 16'h1234);
    rd(6'h02, d);
    check("R11 read 0x02", d, 16'h0);
    wr(6'h3E, 16'hFFFF); wr(6'h10, 16'h0000);
    rd(6'h3E, d);
    check("R11 read 0x3E", d, 16'h0);
    rd(6'h00, d);
    check("R11 mask intact", d, 16'hA5C3);
    check("R11 gpo intact", gpo, 16'h1234);
  endtask

  task automatic t_power();
    logic [15:0] d;
    rd(6'h30, d);
    check("R10 read", d, 16'h0);
    wr(6'h30, 16'h0002);
    check("R10 bit0 clear", 16'(shutdown_req), 16'd0);
    wr(6'h30, 16'h0001);
    check("R10 pulse", 16'(shutdown_req), 16'd1);
    @(negedge clk);
    check("R10 one cycle", 16'(shutdown_req), 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_each_source();
    t_priority();
    t_mask_latency();
    t_level();
    t_regs();
    t_power();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule